// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a synchronous design use an external 8K x 8 asynchronous static RAM. The user side is a plain request/acknowledge port. The requester raises `req_valid` with an address, a direction flag and write data, and holds them until `req_ack` pulses. For a read, the returned byte is on `rsp_rdata` in the same cycle as that pulse.

On the memory side the controller drives the following pins, all from registers:
- a 13-bit address;
- a shared 8-bit data bus;
- an active-low select and an active-high select;
- an active-low write strobe and an active-low output enable.

Every interval on the memory side is a clock-cycle count given by a parameter: address setup, write pulse, write recovery, read access and bus turnaround. Choosing these counts for a given clock lets one controller meet any speed grade.

Between transfers the memory stays selected with both strobes inactive, so it is in output-disable mode. A power-down request deselects the memory, but only between transfers. A transfer already running always completes first. The memory stays deselected until the request is released.

Top module: `asram_ctrl`

## Requirements
- R1: After synchronous reset, `mem_sel_n`=0, `mem_sel`=1, `mem_we_n`=1, `mem_oe_n`=1 and `req_ack`=0.
- R2: While idle and not powered down, the memory stays selected with `mem_we_n`=1 and `mem_oe_n`=1, and the controller does not drive `mem_dq`.
- R3: A write (`req_write`=1) holds `mem_we_n` low for exactly T_WP consecutive cycles, with `mem_oe_n` high. Address and data are presented T_ASU cycles before the write strobe falls and held for T_WR cycles after it rises. The addressed byte then reads back as the written value.
- R4: The controller drives `mem_dq` only during the setup, pulse and recovery phases of a write, and never while `mem_oe_n` is low.
- R5: A read (`req_write`=0) holds `mem_oe_n` low for exactly T_ACC consecutive cycles, with `mem_we_n` high. The bus is captured on the clock edge that ends that window, and the captured byte appears on `rsp_rdata` with the acknowledge.
- R6: Bus turnaround takes at least T_OHZ cycles in each direction. The controller's driver turns on no sooner than T_OHZ cycles after `mem_oe_n` rises. `mem_oe_n` falls no sooner than T_OHZ cycles after the driver turns off.
- R7: `mem_addr` stays constant while either strobe is active, and from request acceptance until the acknowledge.
- R8: Each accepted request produces exactly one acknowledge, one cycle wide.
- R9: While `pd_req` is high between transfers, `mem_sel_n`=1 and `mem_sel`=0, both strobes are high, and no request is accepted or acknowledged. When `pd_req` is released, a pending request proceeds.
- R10: Raising `pd_req` during a transfer neither shortens nor stops it. The acknowledge still arrives on time, and deselection follows afterwards.
- R11: Latency is fixed. A write is acknowledged T_ASU+T_WP+T_WR cycles after the accepting edge, and a read 2*T_OHZ+T_ACC cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request pending; held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read result, valid with `req_ack` after a read |
| pd_req | input | 1 | Power-down request, honoured between transfers |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_dq | inout | DATA_W | Shared memory data bus |
| mem_sel_n | output | 1 | Active-low memory select |
| mem_sel | output | 1 | Active-high memory select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |

## Verification
The properties assume that the requester keeps `req_valid` and its fields steady until the acknowledge, and then drops the request for at least one cycle. They also assume that the memory drives the bus only while it is selected with `mem_oe_n` low and `mem_we_n` high. The bench's driver task keeps to the first rule by holding every request until the acknowledge and then idling a cycle. Its memory model keeps to the second by gating its driver on exactly that pin combination. Power-down is only raised between tasks, or at a point the bench chooses during a transfer, and never with a request that the requester withdraws.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PDOWN,
    ST_WSET,
    ST_WPUL,
    ST_WREC,
    ST_RSET,
    ST_RACC,
    ST_RHLD,
    ST_DONE
  } ctl_st_e;

  function automatic logic st_is_write(ctl_st_e s);
    return (s == ST_WSET) || (s == ST_WPUL) || (s == ST_WREC);
  endfunction

endpackage

// File: rtl/asram_interval.sv
module asram_interval #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int T_ASU = 2,
  parameter int T_WP  = 15,
  parameter int T_WR  = 1,
  parameter int T_ACC = 18,
  parameter int T_OHZ = 8,
  parameter int CNT_W = 5
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    req_valid,
  input  logic    req_write,
  input  logic    pd_req,
  output logic    accept,
  output logic    capture,
  output ctl_st_e st_q,
  output ctl_st_e st_d
);

  logic             tmr_exp;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;

  // each state lasts (span + 1) cycles once entered
  function automatic logic [CNT_W-1:0] span_of(ctl_st_e s);
    case (s)
      ST_WSET: return CNT_W'(T_ASU - 1);
      ST_WPUL: return CNT_W'(T_WP - 1);
      ST_WREC: return CNT_W'(T_WR - 1);
      ST_RSET: return CNT_W'(T_OHZ - 1);
      ST_RACC: return CNT_W'(T_ACC - 1);
      ST_RHLD: return CNT_W'(T_OHZ - 1);
      default: return '0;
    endcase
  endfunction

  assign accept  = (st_q == ST_IDLE) && !pd_req && req_valid;
  assign capture = (st_q == ST_RACC) && tmr_exp;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: begin
        if (pd_req)         st_d = ST_PDOWN;
        else if (req_valid) st_d = req_write ? ST_WSET : ST_RSET;
      end
      ST_PDOWN: if (!pd_req)  st_d = ST_IDLE;
      ST_WSET:  if (tmr_exp)  st_d = ST_WPUL;
      ST_WPUL:  if (tmr_exp)  st_d = ST_WREC;
      ST_WREC:  if (tmr_exp)  st_d = ST_DONE;
      ST_RSET:  if (tmr_exp)  st_d = ST_RACC;
      ST_RACC:  if (tmr_exp)  st_d = ST_RHLD;
      ST_RHLD:  if (tmr_exp)  st_d = ST_DONE;
      ST_DONE:                st_d = ST_IDLE;
      default:                st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  assign tmr_load = (st_d != st_q);
  assign tmr_val  = span_of(st_d);

  asram_interval #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

endmodule

// File: rtl/asram_pinbank.sv
module asram_pinbank
  import asram_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_st_e           st_d,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] pin_addr,
  output logic [DATA_W-1:0] pin_wdata,
  output logic              pin_sel_n,
  output logic              pin_sel,
  output logic              pin_we_n,
  output logic              pin_oe_n,
  output logic              drv_en,
  output logic              ack
);

  // every pin is a flop loaded from the next state, so pins switch with it
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_sel_n <= 1'b0;
      pin_sel   <= 1'b1;
      pin_we_n  <= 1'b1;
      pin_oe_n  <= 1'b1;
      drv_en    <= 1'b0;
      ack       <= 1'b0;
    end else begin
      pin_sel_n <= (st_d == ST_PDOWN);
      pin_sel   <= (st_d != ST_PDOWN);
      pin_we_n  <= (st_d != ST_WPUL);
      pin_oe_n  <= (st_d != ST_RACC);
      drv_en    <= st_is_write(st_d);
      ack       <= (st_d == ST_DONE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_addr  <= '0;
      pin_wdata <= '0;
    end else if (accept) begin
      pin_addr  <= req_addr;
      pin_wdata <= req_wdata;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int T_ASU  = 2,
  parameter int T_WP   = 15,
  parameter int T_WR   = 1,
  parameter int T_ACC  = 18,
  parameter int T_OHZ  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              pd_req,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_we_n,
  output logic              mem_oe_n
);

  localparam int T_M1  = (T_ASU > T_WP) ? T_ASU : T_WP;
  localparam int T_M2  = (T_WR > T_ACC) ? T_WR : T_ACC;
  localparam int T_M3  = (T_M1 > T_M2) ? T_M1 : T_M2;
  localparam int T_MAX = (T_M3 > T_OHZ) ? T_M3 : T_OHZ;
  localparam int CNT_W = (T_MAX < 2) ? 1 : $clog2(T_MAX);

  ctl_st_e           st_q;
  ctl_st_e           st_d;
  logic              accept;
  logic              capture;
  logic              drv_en;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  asram_seq #(
    .T_ASU (T_ASU),
    .T_WP  (T_WP),
    .T_WR  (T_WR),
    .T_ACC (T_ACC),
    .T_OHZ (T_OHZ),
    .CNT_W (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .pd_req    (pd_req),
    .accept    (accept),
    .capture   (capture),
    .st_q      (st_q),
    .st_d      (st_d)
  );

  asram_pinbank #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_pins (
    .clk       (clk),
    .rst       (rst),
    .st_d      (st_d),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .pin_addr  (mem_addr),
    .pin_wdata (wdata_q),
    .pin_sel_n (mem_sel_n),
    .pin_sel   (mem_sel),
    .pin_we_n  (mem_we_n),
    .pin_oe_n  (mem_oe_n),
    .drv_en    (drv_en),
    .ack       (req_ack)
  );

  // per-bit bus driver
  for (genvar b = 0; b < DATA_W; b++) begin : g_dq
    assign mem_dq[b] = drv_en ? wdata_q[b] : 1'bz;
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (capture) rdata_q <= mem_dq;
  end

  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W = 13,
  parameter int T_WP   = 15,
  parameter int T_ACC  = 18,
  parameter int T_OHZ  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ack,
  input logic              sel_n,
  input logic              sel,
  input logic              we_n,
  input logic              oe_n,
  input logic              drv_en,
  input logic [ADDR_W-1:0] addr
);

  localparam int SAT = 1 << 20;

  int we_run;
  int oe_run;
  int oe_gap;
  int drv_gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_run  <= 0;
      oe_run  <= 0;
      oe_gap  <= SAT;
      drv_gap <= SAT;
    end else begin
      we_run  <= we_n ? 0 : we_run + 1;
      oe_run  <= oe_n ? 0 : oe_run + 1;
      oe_gap  <= !oe_n ? 0 : ((oe_gap < SAT) ? oe_gap + 1 : oe_gap);
      drv_gap <= drv_en ? 0 : ((drv_gap < SAT) ? drv_gap + 1 : drv_gap);
    end
  end

  a_r3_we_width: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (we_run == T_WP));

  a_r4_drv_not_oe: assert property (@(posedge clk) disable iff (rst)
    drv_en |-> oe_n);

  a_r5_oe_width: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_n) |-> (oe_run == T_ACC));

  a_r5_read_we_high: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> we_n);

  a_r6_drv_after_oe: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_en) |-> (oe_gap >= T_OHZ));

  a_r6_oe_after_drv: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_n) |-> (drv_gap >= T_OHZ));

  a_r7_addr_we: assert property (@(posedge clk) disable iff (rst)
    (!we_n && $past(!we_n)) |-> $stable(addr));

  a_r7_addr_oe: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && $past(!oe_n)) |-> $stable(addr));

  a_r8_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack);

  a_r9_pd_quiet: assert property (@(posedge clk) disable iff (rst)
    (sel_n || !sel) |-> (we_n && oe_n && !drv_en));

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .T_WP   (T_WP),
  .T_ACC  (T_ACC),
  .T_OHZ  (T_OHZ)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .req_ack (req_ack),
  .sel_n   (mem_sel_n),
  .sel     (mem_sel),
  .we_n    (mem_we_n),
  .oe_n    (mem_oe_n),
  .drv_en  (drv_en),
  .addr    (mem_addr)
);

// File: tb/asram_ctrl_tb_top.sv
module asram_ctrl_tb_top;

  localparam int AW    = 13;
  localparam int DW    = 8;
  localparam int P_ASU = 2;
  localparam int P_WP  = 15;
  localparam int P_WR  = 1;
  localparam int P_ACC = 18;
  localparam int P_OHZ = 8;
  localparam int LAT_W = P_ASU + P_WP + P_WR;
  localparam int LAT_R = 2 * P_OHZ + P_ACC;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ack;
  logic [DW-1:0] rsp_rdata;
  logic          pd_req = 1'b0;
  logic [AW-1:0] mem_addr;
  wire  [DW-1:0] mem_dq;
  logic          mem_sel_n;
  logic          mem_sel;
  logic          mem_we_n;
  logic          mem_oe_n;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  asram_ctrl #(
    .ADDR_W (AW), .DATA_W (DW),
    .T_ASU (P_ASU), .T_WP (P_WP), .T_WR (P_WR),
    .T_ACC (P_ACC), .T_OHZ (P_OHZ)
  ) dut_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ack   (req_ack),
    .rsp_rdata (rsp_rdata),
    .pd_req    (pd_req),
    .mem_addr  (mem_addr),
    .mem_dq    (mem_dq),
    .mem_sel_n (mem_sel_n),
    .mem_sel   (mem_sel),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n)
  );

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  // ---------------- memory model ----------------
  logic [DW-1:0] mdl_mem [int];
  logic [DW-1:0] mdl_q = '0;
  logic          mdl_drv;
  logic          prev_we_n = 1'b1;

  assign mdl_drv = !mem_sel_n && mem_sel && !mem_oe_n && mem_we_n;
  assign mem_dq  = mdl_drv ? mdl_q : 'z;

  always @(negedge clk) begin
    if (!mem_sel_n && mem_sel && !prev_we_n && mem_we_n)
      mdl_mem[int'(mem_addr)] = mem_dq;
    prev_we_n <= mem_we_n;
    mdl_q <= mdl_mem.exists(int'(mem_addr)) ? mdl_mem[int'(mem_addr)] : '0;
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    bit            is_rd;
    logic [DW-1:0] data;
  } exp_t;

  exp_t          exp_q[$];
  logic [DW-1:0] shadow [int];
  logic [AW-1:0] cur_addr = '0;

  always @(negedge clk) begin
    if (!rst && req_ack) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 acknowledge without request", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.is_rd) chk(rsp_rdata == e.data, "R5 read data", int'(rsp_rdata), int'(e.data));
      end
    end
  end

  // ---------------- pin-timing monitor ----------------
  int  we_low = 0;
  int  oe_low = 0;
  int  since_oe = 1000;
  int  since_we = 1000;
  bit  prev_ack = 1'b0;
  bit  prev_oe_n = 1'b1;
  bit  prev_we2 = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_ack && req_ack) chk(1'b0, "R8 acknowledge wider than one cycle", 2, 1);
      if (!mem_we_n && prev_we2) chk(since_oe >= P_OHZ + P_ASU, "R6 OE-high to write strobe gap", since_oe, P_OHZ + P_ASU);
      if (!mem_oe_n && prev_oe_n) chk(since_we >= P_WR + P_OHZ, "R6 write strobe to OE-low gap", since_we, P_WR + P_OHZ);
      if (mem_we_n && !prev_we2) chk(we_low == P_WP, "R3 write strobe width", we_low, P_WP);
      if (mem_oe_n && !prev_oe_n) chk(oe_low == P_ACC, "R5 output enable width", oe_low, P_ACC);
      if (!mem_we_n || !mem_oe_n) begin
        if (mem_addr != cur_addr) chk(1'b0, "R7 address moved during strobe", int'(mem_addr), int'(cur_addr));
        if (!mem_we_n && !mem_oe_n) chk(1'b0, "R5 both strobes low", 0, 1);
      end
      we_low   = mem_we_n ? 0 : we_low + 1;
      oe_low   = mem_oe_n ? 0 : oe_low + 1;
      since_oe = mem_oe_n ? since_oe + 1 : 0;
      since_we = mem_we_n ? since_we + 1 : 0;
    end
    prev_ack  = req_ack;
    prev_oe_n = mem_oe_n;
    prev_we2  = mem_we_n;
  end

  // ---------------- driver ----------------
  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int   n;
    exp_t e;
    @(negedge clk);
    e.is_rd = !wr;
    e.data  = shadow.exists(int'(a)) ? shadow[int'(a)] : '0;
    if (wr) shadow[int'(a)] = d;
    exp_q.push_back(e);
    cur_addr  = a;
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!req_ack && n < 300);
    req_valid = 1'b0;
    if (wr) chk(n == LAT_W + 1, "R11 write latency", n, LAT_W + 1);
    else    chk(n == LAT_R + 1, "R11 read latency", n, LAT_R + 1);
  endtask

  task automatic idle_pins(input string tag);
    chk(mem_sel_n == 1'b0, tag, int'(mem_sel_n), 0);
    chk(mem_sel == 1'b1, tag, int'(mem_sel), 1);
    chk(mem_we_n == 1'b1, tag, int'(mem_we_n), 1);
    chk(mem_oe_n == 1'b1, tag, int'(mem_oe_n), 1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    idle_pins("R1 reset pin state");
    chk(req_ack == 1'b0, "R1 reset acknowledge", int'(req_ack), 0);

    // R3 / R5 basic write then read
    do_op(1'b1, 13'h0000, 8'h5A);
    do_op(1'b0, 13'h0000, 8'h00);

    // boundary addresses and extreme patterns
    do_op(1'b1, 13'h1FFF, 8'hFF);
    do_op(1'b1, 13'h0001, 8'h00);
    do_op(1'b1, 13'h1000, 8'hA5);
    do_op(1'b0, 13'h1FFF, 8'h00);
    do_op(1'b0, 13'h0001, 8'h00);
    do_op(1'b0, 13'h1000, 8'h00);
    // read of a never-written location returns the model's cleared value
    do_op(1'b0, 13'h0ABC, 8'h00);

    // overwrite then immediate read-back (R6 turnaround both ways)
    do_op(1'b1, 13'h1FFF, 8'h3C);
    do_op(1'b0, 13'h1FFF, 8'h00);
    do_op(1'b1, 13'h1FFF, 8'hC3);

    // varied patterns
    for (int i = 0; i < 16; i++) do_op(1'b1, AW'(i * 397), DW'(i * 37 + 3));
    for (int i = 15; i >= 0; i--) do_op(1'b0, AW'(i * 397), 8'h00);

    // R2 idle state between transfers
    repeat (3) @(negedge clk);
    idle_pins("R2 idle output-disable");

    // R10 power-down raised during a write does not cut it short
    fork
      do_op(1'b1, 13'h0777, 8'h81);
      begin
        repeat (4) @(negedge clk);
        pd_req = 1'b1;
      end
    join
    repeat (3) @(negedge clk);
    chk(mem_sel_n == 1'b1, "R10 deselect after transfer", int'(mem_sel_n), 1);

    // R9 powered down: deselected, requests held off
    chk(mem_sel == 1'b0, "R9 active-high select low", int'(mem_sel), 0);
    chk(mem_we_n == 1'b1 && mem_oe_n == 1'b1, "R9 strobes inactive", int'({mem_we_n, mem_oe_n}), 3);
    begin
      exp_t e;
      int   n;
      e.is_rd = 1'b1;
      e.data  = shadow[int'(13'h0777)];
      exp_q.push_back(e);
      cur_addr  = 13'h0777;
      req_valid = 1'b1;
      req_write = 1'b0;
      req_addr  = 13'h0777;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        chk(req_ack == 1'b0 && mem_oe_n == 1'b1, "R9 request held during power-down",
            int'(req_ack), 0);
      end
      chk(mem_sel_n == 1'b1, "R9 still deselected", int'(mem_sel_n), 1);
      pd_req = 1'b0;
      n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (!req_ack && n < 300);
      req_valid = 1'b0;
      chk(n == LAT_R + 2, "R9 pending request resumes after release", n, LAT_R + 2);
    end

    repeat (3) @(negedge clk);
    idle_pins("R2 idle after power-down");
    do_op(1'b0, 13'h0000, 8'h00);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R8 every request acknowledged", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule